// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock waveform of an I2C master. Two programmable 9-bit counts set the length of the low phase and of the high phase, measured in ticks of a count clock. The count clock is an enable derived from the system clock, running either at the full system rate or at half of it.

The block drives SCL low through an open-drain enable and watches the bus through a sampled copy of the SCL pin. The low phase is timed from the very cycle the block starts pulling the line down. The high phase is timed only after the line is actually seen high, so the rise time and any clock stretching by a slave are added on top of the programmed high count.

A byte sequencer requests clocking with a run level. In return it receives two single-cycle strobes: one telling it when to change SDA during the low phase, and one telling it when to sample SDA in the middle of the high phase. The state machine has four states:
- `ST_IDLE`: the line is released.
- `ST_LOW`: the line is driven low and the low count runs.
- `ST_WAIT_HI`: the line is released and the block waits for it to read high.
- `ST_HIGH`: the high count runs.

The transitions are:
- START (`ST_IDLE` to `ST_LOW`): run requested, on a count tick.
- LOW_DONE (`ST_LOW` to `ST_WAIT_HI`): low count reached, on a tick.
- SEEN_HIGH (`ST_WAIT_HI` to `ST_HIGH`): sampled SCL reads high.
- HIGH_NEXT (`ST_HIGH` to `ST_LOW`): high count reached while run is still requested.
- HIGH_STOP (`ST_HIGH` to `ST_IDLE`): high count reached with run withdrawn.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, `scl_drive_low`, `sda_change_stb` and `sample_stb` are all 0.
- R2: The low phase lasts exactly `low_count` count ticks. The full 9-bit range is honoured (for example 0x105 gives 261 ticks), and counting starts in the first cycle in which `scl_drive_low` is 1.
- R3: The high count does not advance until the sampled `scl_in` reads high. With divide-by-1, the released time between two low phases is `high_count` + 2 + S cycles: one cycle for the input sampling register, one for the state update, and S cycles for which the bus holds SCL low after release (stretching).
- R4: A count value of 0 is treated as 1 for either phase.
- R5: With `div2_sel`=1, a count tick occurs every second system clock, so the low phase lasts 2 x `low_count` cycles. With `div2_sel`=0, a tick occurs every cycle.
- R6: `sda_change_stb` is a one-cycle pulse in the low-phase cycle whose closing edge lies one count tick after SCL went low. This is the first low cycle with divide-by-1 and the second low cycle with divide-by-2.
- R7: `sample_stb` is a one-cycle pulse in the high-phase cycle in which the high count value equals floor(effective high count / 2). With divide-by-1 this is released cycle 2 + S + floor(`high_count`/2), counted from 0.
- R8: While `run_req` is 0 and the block is idle, `scl_drive_low` stays 0.
- R9: If `run_req` drops during a clock period, the current low phase and high phase complete at their full lengths, and SCL then stays released.
- R10: While `run_req` stays 1, the next low phase begins in the cycle immediately after the high phase ends, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| low_count | input | 9 | Low-phase length in count ticks (0 acts as 1) |
| high_count | input | 9 | High-phase length in count ticks (0 acts as 1) |
| div2_sel | input | 1 | 1: count clock is system clock / 2; 0: count clock equals system clock |
| run_req | input | 1 | Level request from the byte sequencer to generate clock periods |
| scl_in | input | 1 | SCL pin level as seen on the bus |
| scl_drive_low | output | 1 | Open-drain enable; 1 pulls SCL low |
| sda_change_stb | output | 1 | One-cycle strobe marking the SDA change point |
| sample_stb | output | 1 | One-cycle strobe marking the SDA sample point |

## Verification
Each result is due in a fixed cycle:
- The low phase appears at the outputs immediately after the START edge and lasts L (or 2L) cycles.
- The released gap is exactly H + 2 + S cycles, because the sampled input and the state register each add one cycle.
- The SDA strobe lands at low index 0, or 1 with divide-by-2.
- The sample strobe lands at released index 2 + S + floor(H/2).

The bench samples every output on the falling clock edge. It records the index at which each strobe occurs and the length of each phase by counting those samples, and compares them with these formulas. Configuration changes are made only after a long idle stretch, so no period is ever measured with mixed settings.

// File: rtl/i2c_scl_pkg.sv
`timescale 1ns/1ps
package i2c_scl_pkg;

    // Clock-generator states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW     = 2'd1,
        ST_WAIT_HI = 2'd2,
        ST_HIGH    = 2'd3
    } scl_state_e;

endpackage

// File: rtl/scl_count_tick.sv
`timescale 1ns/1ps
// Count-clock enable: every cycle, or every second cycle.
module scl_count_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic div2_sel,
    output logic tick
);
    logic toggle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toggle_q <= 1'b0;
        end else if (div2_sel) begin
            toggle_q <= ~toggle_q;
        end else begin
            toggle_q <= 1'b0;
        end
    end

    always_comb begin
        tick = div2_sel ? toggle_q : 1'b1;
    end

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div2_sel && tick) |=> (!div2_sel || !tick));

endmodule

// File: rtl/scl_input_sampler.sv
`timescale 1ns/1ps
// Registers the SCL pin level through a parameterised chain of flops.
module scl_input_sampler #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level_q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        level_q = chain_q[STAGES-1];
    end

endmodule

// File: rtl/scl_phase_counter.sv
`timescale 1ns/1ps
// Phase counter with synchronous clear and tick-qualified increment.
module scl_phase_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/i2c_scl_timer.sv
`timescale 1ns/1ps
module i2c_scl_timer #(
    parameter int CNT_W       = 9,
    parameter int SYNC_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    input  logic             div2_sel,
    input  logic             run_req,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             sda_change_stb,
    output logic             sample_stb
);
    import i2c_scl_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    scl_state_e       state, nxt;
    logic             tick;
    logic             scl_hi;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lo_eff, hi_eff, hi_mid;
    logic             low_last, high_last;
    logic             cnt_clr, cnt_inc;

    scl_count_tick u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .div2_sel (div2_sel),
        .tick     (tick)
    );

    scl_input_sampler #(.STAGES(SYNC_STAGES)) u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (scl_in),
        .level_q (scl_hi)
    );

    scl_phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    // Effective counts: zero is promoted to one
    always_comb begin
        lo_eff    = (low_count  == '0) ? ONE : low_count;
        hi_eff    = (high_count == '0) ? ONE : high_count;
        hi_mid    = hi_eff >> 1;
        low_last  = (cnt == lo_eff - ONE);
        high_last = (cnt == hi_eff - ONE);
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (run_req && tick)    nxt = ST_LOW;       // START
            ST_LOW:     if (tick && low_last)   nxt = ST_WAIT_HI;   // LOW_DONE
            ST_WAIT_HI: if (scl_hi)             nxt = ST_HIGH;      // SEEN_HIGH
            ST_HIGH:    if (tick && high_last)                      // HIGH_NEXT / HIGH_STOP
                            nxt = run_req ? ST_LOW : ST_IDLE;
            default:                            nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Counter control: clear on every state change, count ticks in timed phases
    always_comb begin
        cnt_clr = (nxt != state);
        cnt_inc = tick && ((state == ST_LOW) || (state == ST_HIGH));
    end

    // Outputs
    always_comb begin
        scl_drive_low  = 1'b0;
        sda_change_stb = 1'b0;
        sample_stb     = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_LOW: begin
                scl_drive_low  = 1'b1;
                sda_change_stb = tick && (cnt == '0);
            end
            ST_WAIT_HI: ;
            ST_HIGH: begin
                sample_stb = tick && (cnt == hi_mid);
            end
            default: ;
        endcase
    end

    // R3
    wait_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_HI) |-> (cnt == '0));

    // R3
    min_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |=> !scl_drive_low);

    // R8
    start_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> $past(run_req));

    // R6
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_change_stb && sample_stb));

    // R7
    sample_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> !scl_drive_low);

endmodule

// File: tb/test_i2c_scl_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] low_count = 9'd5;
    logic [8:0] high_count = 9'd4;
    logic       div2_sel = 1'b0;
    logic       run_req = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_in;
    logic       scl_drive_low, sda_change_stb, sample_stb;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Open-drain bus model with pull-up and optional slave stretching
    assign scl_in = !scl_drive_low && !stretch;

    i2c_scl_timer i_i2c_scl_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .low_count      (low_count),
        .high_count     (high_count),
        .div2_sel       (div2_sel),
        .run_req        (run_req),
        .scl_in         (scl_in),
        .scl_drive_low  (scl_drive_low),
        .sda_change_stb (sda_change_stb),
        .sample_stb     (sample_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Waits for a fresh low phase, then measures low length, SDA strobe index,
    // released length and sample strobe index. Stretch of s cycles after release.
    task automatic capture(input int s, input int hi_limit,
                           output int lo_len, output int lo_stb,
                           output int hi_len, output int hi_stb);
        int guard;
        lo_stb = -1; hi_stb = -1;
        guard = 0;
        @(negedge clk);
        while (scl_drive_low && guard < 3000) begin guard++; @(negedge clk); end
        while (!scl_drive_low && guard < 3000) begin guard++; @(negedge clk); end
        if (s > 0) stretch = 1'b1;
        lo_len = 0;
        while (scl_drive_low && lo_len < 3000) begin
            if (sda_change_stb && lo_stb < 0) lo_stb = lo_len;
            lo_len++;
            @(negedge clk);
        end
        hi_len = 0;
        while (!scl_drive_low && hi_len < hi_limit) begin
            if (sample_stb && hi_stb < 0) hi_stb = hi_len;
            if (hi_len == s) stretch = 1'b0;
            hi_len++;
            @(negedge clk);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        run_req = 1'b0;
        repeat (700) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(scl_drive_low == 1'b0, "R1 drive_low", scl_drive_low, 0);
        check(sda_change_stb == 1'b0 && sample_stb == 1'b0, "R1 strobes",
              sda_change_stb + sample_stb, 0);
    endtask

    task automatic t_idle();
        int seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (scl_drive_low) seen++;
        end
        check(seen == 0, "R8 idle low cycles", seen, 0);
    endtask

    task automatic t_period(input int l, input int h, input int s, input string tag);
        int ll, ls, hl, hs, le, he;
        le = (l == 0) ? 1 : l;
        he = (h == 0) ? 1 : h;
        @(negedge clk);
        div2_sel = 1'b0; low_count = 9'(l); high_count = 9'(h); run_req = 1'b1;
        capture(s, 3000, ll, ls, hl, hs);
        check(ll == le, {tag, " R2 low length"}, ll, le);
        check(ls == 0, {tag, " R6 sda strobe index"}, ls, 0);
        // R10: released gap ends with the next low phase, no idle cycles
        check(hl == he + 2 + s, {tag, " R3 R10 released length"}, hl, he + 2 + s);
        check(hs == 2 + s + he/2, {tag, " R7 sample strobe index"}, hs, 2 + s + he/2);
        go_idle();
    endtask

    task automatic t_zero();
        // R4: zero counts act as one
        t_period(0, 0, 0, "R4 zero");
    endtask

    task automatic t_div2();
        int ll, ls, hl, hs;
        @(negedge clk);
        div2_sel = 1'b1; low_count = 9'd4; high_count = 9'd3; run_req = 1'b1;
        capture(0, 3000, ll, ls, hl, hs);
        check(ll == 8, "R5 div2 low length", ll, 8);
        check(ls == 1, "R6 div2 sda strobe index", ls, 1);
        go_idle();
        div2_sel = 1'b0;
    endtask

    task automatic t_drop();
        int ll, ls, hl, hs;
        @(negedge clk);
        div2_sel = 1'b0; low_count = 9'd4; high_count = 9'd4; run_req = 1'b1;
        // wait for low, then withdraw run
        while (!scl_drive_low) @(negedge clk);
        run_req = 1'b0;
        while (scl_drive_low) @(negedge clk);
        @(negedge clk);
        run_req = 1'b1;  // re-raise to capture a complete period cleanly
        capture(0, 3000, ll, ls, hl, hs);
        run_req = 1'b0;
        // now capture period during which run is dropped at first low cycle
        go_idle();
        @(negedge clk);
        run_req = 1'b1;
        ll = 0; hl = 0; hs = -1;
        while (!scl_drive_low) @(negedge clk);
        run_req = 1'b0;
        while (scl_drive_low) begin ll++; @(negedge clk); end
        while (!scl_drive_low && hl < 64) begin
            if (sample_stb && hs < 0) hs = hl;
            hl++;
            @(negedge clk);
        end
        check(ll == 4, "R9 low completes", ll, 4);
        check(hs == 4, "R9 high completes (sample index)", hs, 4);
        check(hl == 64, "R9 stays released", hl, 64);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_period(5, 4, 0, "basic");
        t_zero();
        t_period(261, 258, 0, "wide");
        t_period(3, 3, 5, "stretch");
        t_period(2, 7, 0, "odd");
        t_div2();
        t_drop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule